// File: doc/BRIEF.md
# Audio Sample Error Concealer

This block hides audio samples that upstream error correction could not repair. Each input strobe carries one signed sample per channel and one error flag per channel. Each channel has its own history and its own decision logic.

A good sample is passed on unchanged. A flagged sample is replaced in one of two ways:
- If the sample after it is good, it becomes the arithmetic mean of the last good value and that next good sample. This covers both a lone bad sample and the final sample of a longer bad run.
- If the sample after it is also flagged, it repeats the last good value.

Because of this rule, a burst of errors holds the level steady, and the step back to real data is split halfway.

To make the decision, the block looks one sample ahead. The result for sample n is therefore presented one cycle after the strobe that delivers sample n+2. Idle cycles between strobes are allowed and leave all state untouched. The block sits directly in the audio path after error correction and before any muting or output formatting.

Top module: `sample_concealer`

## Requirements
- R1: While reset is applied, and in the cycles after it until the first output, `out_valid` is 0 and `out_data` is 0.
- R2: The result for input sample n is shown with `out_valid` high in the cycle after the input strobe that carries sample n+2. The first two strobes after reset give no output. After that, every strobe gives exactly one output pulse, and `out_valid` is never high in a cycle that does not follow a strobe.
- R3: A sample whose error flag is 0 is output unchanged and becomes that channel's last good value.
- R4: A flagged sample with good samples on both sides is output as floor((prev + next) / 2). This is computed as the sum of the two signed samples, shifted arithmetically right by one bit.
- R5: In a run of two or more flagged samples, every sample except the last one is output as the last good value.
- R6: The last flagged sample of a run of two or more is output as floor((last good + first good after the run) / 2).
- R7: Before any good sample has been seen since reset, the last good value is 0.
- R8: Each channel's flags, history and outputs are independent of the other channel. Channel c occupies bits [16c+15:16c] of `in_data` and `out_data`, and bit c of `in_err`.
- R9: The mean never overflows. Two samples of 32767 give 32767, and two samples of -32768 give -32768.
- R10: In a cycle with `in_valid` low, neither the output nor the channel history changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | One input sample set present this cycle |
| in_err | input | 2 | Per-channel error flag, bit c for channel c |
| in_data | input | 32 | Per-channel signed sample, channel c in bits [16c+15:16c] |
| out_valid | output | 1 | One concealed sample set present this cycle |
| out_data | output | 32 | Per-channel concealed sample, same packing as the input |

## Verification
The bench feeds the block several kinds of streams:
- Clean data, to show plain pass-through.
- Isolated flags, to exercise the bridging mean.
- Bursts of two and of three, to tell holding apart from the halfway recovery step.
- A flagged first sample, to confirm the zero starting level.
- Samples at full-scale positive and negative, to expose any overflow in the mean.

It also gives the two channels different flag patterns, which catches history shared between the channels. It inserts idle gaps of varying length, which catches state that moves without a strobe. A long random stream with a mix of flags then compares every output against an independent model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int SAMPLE_W = 16;
  localparam int LANES    = 2;

  typedef enum logic [1:0] {
    SC_PASS   = 2'd0,
    SC_BRIDGE = 2'd1,
    SC_HOLD   = 2'd2
  } sc_pick_t;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sc_fill.sv
module sc_fill (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic primed,
  output logic out_valid
);
  logic [1:0] cnt_q, cnt_d;
  logic       ov_q, ov_d;

  always_comb begin
    cnt_d  = cnt_q;
    ov_d   = 1'b0;
    primed = (cnt_q == 2'd2);
    if (strobe) begin
      if (!primed) cnt_d = cnt_q + 2'd1;
      ov_d = primed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      ov_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ov_q  <= ov_d;
    end
  end

  assign out_valid = ov_q;

  // R2: an output pulse only follows a strobe
  p_pulse_follows_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> $past(strobe));
endmodule

// File: rtl/sc_lane.sv
module sc_lane
  import sc_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         primed,
  input  logic [W-1:0] in_s,
  input  logic         in_e,
  output logic [W-1:0] out_s
);
  logic [W-1:0] mid_q, ahd_q, last_q, res_q;
  logic         mid_e, ahd_e;
  logic [W-1:0] mid_d, ahd_d, last_d, res_d;
  logic         mid_ed, ahd_ed;
  logic signed [W:0] sum;
  logic [W-1:0] mean;
  sc_pick_t     pick;

  // mean of last good value and the look-ahead sample, one bit wider so it cannot overflow
  assign sum  = $signed({last_q[W-1], last_q}) + $signed({ahd_q[W-1], ahd_q});
  assign mean = sum[W:1];

  always_comb begin
    if (!mid_e)     pick = SC_PASS;
    else if (ahd_e) pick = SC_HOLD;
    else            pick = SC_BRIDGE;
  end

  always_comb begin
    mid_d  = mid_q;
    mid_ed = mid_e;
    ahd_d  = ahd_q;
    ahd_ed = ahd_e;
    last_d = last_q;
    res_d  = res_q;
    if (strobe) begin
      mid_d  = ahd_q;
      mid_ed = ahd_e;
      ahd_d  = in_s;
      ahd_ed = in_e;
      if (primed) begin
        case (pick)
          SC_PASS:   begin res_d = mid_q; last_d = mid_q; end
          SC_BRIDGE: res_d = mean;
          default:   res_d = last_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= '0;
      mid_e  <= 1'b0;
      ahd_q  <= '0;
      ahd_e  <= 1'b0;
      last_q <= '0;
      res_q  <= '0;
    end else begin
      mid_q  <= mid_d;
      mid_e  <= mid_ed;
      ahd_q  <= ahd_d;
      ahd_e  <= ahd_ed;
      last_q <= last_d;
      res_q  <= res_d;
    end
  end

  assign out_s = res_q;

  // R3: a good sample leaves the lane unchanged
  p_pass_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && primed && !mid_e) |=> (res_q == $past(mid_q)));

  // R5: inside a bad run the held level is repeated
  p_hold_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && primed && mid_e && ahd_e) |=> (res_q == $past(last_q)));

  // R4: a bridged value lies between its two sources
  p_bridge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && primed && mid_e && !ahd_e) |=>
      ((($signed(res_q) >= $signed($past(last_q))) && ($signed(res_q) <= $signed($past(ahd_q)))) ||
       (($signed(res_q) <= $signed($past(last_q))) && ($signed(res_q) >= $signed($past(ahd_q))))));

  // R10: nothing moves without a strobe
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(res_q) && $stable(last_q) && $stable(ahd_q)));
endmodule

// File: rtl/sample_concealer.sv
module sample_concealer
  import sc_pkg::*;
#(
  parameter int W  = SAMPLE_W,
  parameter int CH = LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CH-1:0] in_err,
  input  logic [CH*W-1:0] in_data,
  output logic          out_valid,
  output logic [CH*W-1:0] out_data
);
  logic rst_n_s;
  logic primed;

  sc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sc_fill u_fill (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .strobe    (in_valid),
    .primed    (primed),
    .out_valid (out_valid)
  );

  for (genvar c = 0; c < CH; c++) begin : g_lane
    sc_lane #(.W(W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .strobe (in_valid),
      .primed (primed),
      .in_s   (in_data[c*W +: W]),
      .in_e   (in_err[c]),
      .out_s  (out_data[c*W +: W])
    );
  end

  // R1: outputs quiet until the pipeline is filled
  p_quiet_before_fill_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !primed |-> !out_valid);
endmodule

// File: tb/sim_sample_concealer.sv
module sim_sample_concealer;
  localparam int W  = 16;
  localparam int CH = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [CH-1:0]   in_err = '0;
  logic [CH*W-1:0] in_data = '0;
  logic            out_valid;
  logic [CH*W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit mon_on = 0;

  always #5 clk = ~clk;

  sample_concealer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_err(in_err),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  // model state per channel
  logic [W-1:0] pend_v [CH];
  logic         pend_e [CH];
  logic         prev_e [CH];
  logic [W-1:0] lastg  [CH];
  int           seen;

  logic [CH*W-1:0] exp_q [$];
  int              tag_q [$];

  function automatic logic [W-1:0] avg(input logic [W-1:0] a, input logic [W-1:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    return W'(s >>> 1);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < CH; c++) begin
      pend_v[c] = '0; pend_e[c] = 1'b0; prev_e[c] = 1'b0; lastg[c] = '0; // R7 starts at 0
    end
    seen = 0;
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic send(input logic [W-1:0] d0, input logic [W-1:0] d1,
                      input logic [1:0] e, input int gap);
    logic [CH*W-1:0] ex;
    int tag;
    logic [W-1:0] dv [CH];
    dv[0] = d0; dv[1] = d1;
    tag = 3;
    if (seen > 0) begin
      for (int c = 0; c < CH; c++) begin
        int t;
        if (!pend_e[c]) begin
          ex[c*W +: W] = pend_v[c]; lastg[c] = pend_v[c]; t = 3;    // R3
        end else if (e[c]) begin
          ex[c*W +: W] = lastg[c]; t = 5;                           // R5
        end else begin
          ex[c*W +: W] = avg(lastg[c], dv[c]); t = prev_e[c] ? 6 : 4; // R6 / R4
        end
        if (c == 0) tag = t;
        else if (pend_e[1] != pend_e[0] || e[1] != e[0]) tag = 8;   // R8
      end
      exp_q.push_back(ex); tag_q.push_back(tag);
    end
    for (int c = 0; c < CH; c++) begin
      if (seen > 0) prev_e[c] = pend_e[c];
      pend_v[c] = dv[c]; pend_e[c] = e[c];
    end
    seen++;
    @(negedge clk);
    in_valid = 1'b1; in_err = e; in_data = {d1, d0};
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor: compare at falling edges
  logic [CH*W-1:0] prev_out;
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected output act=%h exp=none", out_data);
        end else begin
          logic [CH*W-1:0] ex;
          int tg;
          ex = exp_q.pop_front(); tg = tag_q.pop_front();
          if (out_data !== ex) begin
            errors++;
            $display("FAIL R%0d act=%h exp=%h", tg, out_data, ex);
          end
        end
      end else if (out_data !== prev_out) begin
        errors++;
        $display("FAIL R10 output moved while idle act=%h exp=%h", out_data, prev_out);
      end
    end
    prev_out = out_data;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check_eq(input string req, input logic [CH*W:0] act, input logic [CH*W:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, ex);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", {out_valid, out_data}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", {out_valid, out_data}, '0);
    prev_out = out_data;
    mon_on = 1;

    // R7: first sample flagged, then a run on ch1 and single on ch0
    send(16'h1234, 16'h0100, 2'b11, 0);
    send(16'h0064, 16'hFF00, 2'b10, 1);
    // R2: no output yet after two strobes
    check_eq("R2", {31'b0, out_valid}, '0);
    send(16'h0066, 16'h0040, 2'b00, 0);
    // R3: clean data
    send(16'h7000, 16'h8000, 2'b00, 2);
    send(16'h0010, 16'hFFF0, 2'b00, 0);
    // R4: lone bad
    send(16'h5555, 16'h1111, 2'b01, 0);
    send(16'hFFF3, 16'h0002, 2'b00, 3);
    // R5 / R6: run of three
    send(16'h0001, 16'h0001, 2'b11, 0);
    send(16'h0002, 16'h0002, 2'b11, 0);
    send(16'h0003, 16'h0003, 2'b11, 0);
    send(16'h0200, 16'hFE00, 2'b00, 0);
    // run of two
    send(16'h0000, 16'h0000, 2'b11, 1);
    send(16'h0000, 16'h0000, 2'b11, 0);
    send(16'hFC01, 16'h03FF, 2'b00, 0);
    // R9: full-scale positive and negative
    send(16'h7FFF, 16'h8000, 2'b00, 0);
    send(16'h0000, 16'h0000, 2'b11, 0);
    send(16'h7FFF, 16'h8000, 2'b00, 0);
    send(16'h8000, 16'h7FFF, 2'b00, 0);
    send(16'h0000, 16'h0000, 2'b11, 0);
    send(16'h8000, 16'h7FFF, 2'b00, 0);
    // R8: opposite patterns on the two channels
    send(16'h0100, 16'h0100, 2'b01, 0);
    send(16'h0200, 16'h0200, 2'b10, 0);
    send(16'h0300, 16'h0300, 2'b01, 0);
    send(16'h0400, 16'h0400, 2'b00, 0);

    // random stream
    for (int i = 0; i < 400; i++) begin
      logic [1:0] e;
      e[0] = ($urandom_range(0, 3) == 0);
      e[1] = ($urandom_range(0, 2) == 0);
      send(W'($urandom), W'($urandom), e, $urandom_range(0, 2));
    end
    repeat (3) @(negedge clk);
    mon_on = 0;
    // R2: exactly one pending result remains after the last strobe
    check_eq("R2", 33'(exp_q.size()), 33'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule